// File: doc/BRIEF.md
# Eight-Level Vectored Interrupt Controller

This block gathers interrupt requests from hardware lines and from a software-issued strobe, and holds each one in a per-source pending bit. Software gives every source a three-bit priority level and a mask bit. The controller finds the highest level that has an unmasked pending source, and offers it to the processor with a request line, the level number and the address of that level's service routine.

A global enable decides whether the request line may rise. Requests that arrive while the enable is clear are still held, and they are offered once it is set. A level that the processor acknowledges is recorded in an in-service register. Only a strictly higher level may then interrupt it. A return strobe from the processor retires the most recent, highest in-service level.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset no source is pending, no level is in service and `irq` is low.
- R2: A request on `hw_req` in any cycle sets that source's pending bit whether `gie` is high or low. `irq` is high only while `gie` is high.
- R3: A masked source (`src_mask` bit = 1) keeps its pending bit but is excluded from arbitration. It becomes eligible in the same cycle its mask bit is cleared.
- R4: Among the eligible sources, the highest priority level is offered. Level 7 is the highest and level 0 the lowest.
- R5: `irq_vec` equals VEC_BASE + `irq_lvl` × VEC_STRIDE (defaults 0x040 and 0x010).
- R6: `cpu_ack` with `irq` high clears the pending bits of all unmasked sources at the offered level and marks that level in service. A request from such a source in the acknowledge cycle stays pending.
- R7: `irq` is high only if the best eligible level is strictly above every level in service.
- R8: `cpu_reti` clears the highest in-service level.
- R9: `sw_set` sets the pending bit of the software source, which is source index NUM_HW (the last one).
- R10: `cpu_ack` while `irq` is low changes nothing.
- R11: The priority of source i is the field `src_prio[3*i +: 3]`, and it may be changed at run time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_req | input | NUM_HW | Hardware request lines, sampled every cycle |
| sw_set | input | 1 | Software interrupt strobe |
| src_mask | input | NUM_HW+1 | Per-source mask, 1 = masked |
| src_prio | input | 3*(NUM_HW+1) | Per-source priority level fields |
| gie | input | 1 | Global interrupt enable |
| cpu_ack | input | 1 | Processor accepts the offered level |
| cpu_reti | input | 1 | Processor returns from the current routine |
| irq | output | 1 | Interrupt request to the processor |
| irq_lvl | output | 3 | Offered priority level |
| irq_vec | output | VEC_W | Service-routine address of the offered level |

## Verification
The hardest states to reach are those with several levels in service at once. In these states a lower pending level must stay hidden until enough returns have been issued. They are also the states in which a request arrives in the very cycle its level is acknowledged. The directed stimulus stacks two levels of service, posts a lower request beneath them and then unwinds them one return at a time. It also raises a source's request together with its own acknowledge. A long pseudo-random phase then mixes requests, masks, run-time priority changes, enable toggles, acknowledges and returns. A behavioural model follows every cycle of it.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int NUM_LVL = 8;
    localparam int LVL_W   = 3;
    typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/pic_level_map.sv
module pic_level_map #(
    parameter int TOT     = 7,
    parameter int NUM_LVL = 8,
    parameter int LVL_W   = 3
) (
    input  logic [TOT-1:0]       pend,
    input  logic [TOT-1:0]       mask,
    input  logic [TOT*LVL_W-1:0] prio,
    output logic [NUM_LVL-1:0]   lvl_act
);
    // one OR-reduction per level over the eligible sources assigned to it
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        always_comb begin
            lvl_act[l] = 1'b0;
            for (int s = 0; s < TOT; s++) begin
                if (pend[s] && !mask[s] && (prio[s*LVL_W +: LVL_W] == LVL_W'(l)))
                    lvl_act[l] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [N-1:0] vec,
    output logic         vld,
    output logic [W-1:0] idx
);
    always_comb begin
        vld = |vec;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (vec[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/pic_vec_gen.sv
module pic_vec_gen #(
    parameter int          LVL_W      = 3,
    parameter int          VEC_W      = 12,
    parameter logic [11:0] VEC_BASE   = 12'h040,
    parameter logic [11:0] VEC_STRIDE = 12'h010
) (
    input  logic [LVL_W-1:0] lvl,
    output logic [VEC_W-1:0] vec
);
    localparam logic [VEC_W-1:0] BASE_W   = VEC_W'(VEC_BASE);
    localparam logic [VEC_W-1:0] STRIDE_W = VEC_W'(VEC_STRIDE);
    assign vec = BASE_W + VEC_W'(lvl) * STRIDE_W;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int          NUM_HW     = 6,
    parameter int          VEC_W      = 12,
    parameter logic [11:0] VEC_BASE   = 12'h040,
    parameter logic [11:0] VEC_STRIDE = 12'h010,
    localparam int         TOT        = NUM_HW + 1,
    localparam int         LVL_W      = pic_pkg::LVL_W,
    localparam int         NUM_LVL    = pic_pkg::NUM_LVL
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_HW-1:0]      hw_req,
    input  logic                   sw_set,
    input  logic [TOT-1:0]         src_mask,
    input  logic [TOT*LVL_W-1:0]   src_prio,
    input  logic                   gie,
    input  logic                   cpu_ack,
    input  logic                   cpu_reti,
    output logic                   irq,
    output logic [LVL_W-1:0]       irq_lvl,
    output logic [VEC_W-1:0]       irq_vec
);
    typedef struct packed {
        logic [TOT-1:0]     pend;
        logic [NUM_LVL-1:0] isr;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_LVL-1:0] lvl_act;
    logic               best_vld, top_vld;
    pic_pkg::lvl_t      best_idx, top_idx;
    logic               ack_ok;
    logic [TOT-1:0]     clr;
    logic [TOT-1:0]     pend_vis;
    logic [NUM_LVL-1:0] isr_vis;

    pic_level_map #(.TOT(TOT), .NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_map (
        .pend    (st_q.pend),
        .mask    (src_mask),
        .prio    (src_prio),
        .lvl_act (lvl_act)
    );

    pic_prio_enc #(.N(NUM_LVL), .W(LVL_W)) u_best (
        .vec (lvl_act),
        .vld (best_vld),
        .idx (best_idx)
    );

    pic_prio_enc #(.N(NUM_LVL), .W(LVL_W)) u_top (
        .vec (st_q.isr),
        .vld (top_vld),
        .idx (top_idx)
    );

    pic_vec_gen #(.LVL_W(LVL_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE),
                  .VEC_STRIDE(VEC_STRIDE)) u_vec (
        .lvl (best_idx),
        .vec (irq_vec)
    );

    always_comb begin
        irq     = gie && best_vld && (!top_vld || (best_idx > top_idx));
        irq_lvl = best_idx;
        ack_ok  = cpu_ack && irq;

        for (int s = 0; s < TOT; s++) begin
            clr[s] = ack_ok && !src_mask[s] && (src_prio[s*LVL_W +: LVL_W] == best_idx);
        end

        st_d      = st_q;
        st_d.pend = (st_q.pend & ~clr) | {sw_set, hw_req};
        if (cpu_reti && top_vld) st_d.isr[top_idx] = 1'b0;
        if (ack_ok)              st_d.isr[best_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_vis = st_q.pend;
    assign isr_vis  = st_q.isr;
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
    parameter int          NUM_HW     = 6,
    parameter int          VEC_W      = 12,
    parameter logic [11:0] VEC_BASE   = 12'h040,
    parameter logic [11:0] VEC_STRIDE = 12'h010,
    parameter int          TOT        = 7,
    parameter int          NUM_LVL    = 8,
    parameter int          LVL_W      = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               gie,
    input logic               irq,
    input logic [LVL_W-1:0]   irq_lvl,
    input logic [VEC_W-1:0]   irq_vec,
    input logic               cpu_ack,
    input logic               cpu_reti,
    input logic               sw_set,
    input logic [TOT-1:0]     pend_q,
    input logic [NUM_LVL-1:0] isr_q
);
    assert_gie_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> gie);

    assert_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_vec == VEC_W'(VEC_BASE) + VEC_W'(irq_lvl) * VEC_W'(VEC_STRIDE)));

    assert_ack_marks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && irq) |=> isr_q[$past(irq_lvl)]);

    assert_strict_preempt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((isr_q >> irq_lvl) == '0));

    assert_reti_pops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_reti && !(cpu_ack && irq) && (isr_q != '0)) |=>
        ($countones(isr_q) == $countones($past(isr_q)) - 1));

    assert_sw_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_set |=> pend_q[TOT-1]);
endmodule

bind prio_irq_ctrl pic_checker #(
    .NUM_HW(NUM_HW), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE),
    .TOT(TOT), .NUM_LVL(NUM_LVL), .LVL_W(LVL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .gie(gie), .irq(irq), .irq_lvl(irq_lvl),
    .irq_vec(irq_vec), .cpu_ack(cpu_ack), .cpu_reti(cpu_reti), .sw_set(sw_set),
    .pend_q(pend_vis), .isr_q(isr_vis)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
    localparam int NUM_HW = 6;
    localparam int TOT    = NUM_HW + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_HW-1:0] hw_req = '0;
    logic              sw_set = 1'b0;
    logic [TOT-1:0]    src_mask = '0;
    logic [TOT*3-1:0]  src_prio = '0;
    logic              gie = 1'b0;
    logic              cpu_ack = 1'b0;
    logic              cpu_reti = 1'b0;
    logic              irq;
    logic [2:0]        irq_lvl;
    logic [11:0]       irq_vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int m_pend[TOT];
    int m_isr[8];

    always #2 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .sw_set(sw_set),
        .src_mask(src_mask), .src_prio(src_prio), .gie(gie), .cpu_ack(cpu_ack),
        .cpu_reti(cpu_reti), .irq(irq), .irq_lvl(irq_lvl), .irq_vec(irq_vec)
    );

    function automatic int prio_of(int s);
        return int'(src_prio[s*3 +: 3]);
    endfunction

    function automatic int best_lvl();
        int b = -1;
        for (int s = 0; s < TOT; s++)
            if (m_pend[s] != 0 && !src_mask[s] && prio_of(s) > b) b = prio_of(s);
        return b;
    endfunction

    function automatic int top_isr();
        int t = -1;
        for (int l = 0; l < 8; l++) if (m_isr[l] != 0) t = l;
        return t;
    endfunction

    task automatic set_prio(int s, int l);
        src_prio[s*3 +: 3] = 3'(l);
    endtask

    task automatic check(string tag, int got, int exp, string what);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, exp);
        end
    endtask

    // one cycle: compare outputs, cross the edge, advance the model, clear strobes
    task automatic cyc(string tag);
        int b, t, e_irq, e_lvl;
        #1;
        b = best_lvl();
        t = top_isr();
        e_irq = (gie && b >= 0 && b > t) ? 1 : 0;
        e_lvl = (b < 0) ? 0 : b;
        check(tag, int'(irq), e_irq, "irq");
        if (e_irq != 0) begin
            check(tag, int'(irq_lvl), e_lvl, "irq_lvl");
            check(tag, int'(irq_vec), 'h040 + e_lvl * 'h010, "irq_vec");
        end
        @(posedge clk);
        if (cpu_ack && e_irq != 0)
            for (int s = 0; s < TOT; s++)
                if (!src_mask[s] && prio_of(s) == b) m_pend[s] = 0;
        if (cpu_reti && t >= 0) m_isr[t] = 0;
        if (cpu_ack && e_irq != 0) m_isr[b] = 1;
        for (int s = 0; s < NUM_HW; s++) if (hw_req[s]) m_pend[s] = 1;
        if (sw_set) m_pend[TOT-1] = 1;
        @(negedge clk);
        hw_req = '0; sw_set = 0; cpu_ack = 0; cpu_reti = 0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        for (int s = 0; s < TOT; s++) m_pend[s] = 0;
        for (int l = 0; l < 8; l++) m_isr[l] = 0;
        set_prio(0, 3); set_prio(1, 5); set_prio(2, 2); set_prio(3, 7);
        set_prio(4, 3); set_prio(5, 1); set_prio(6, 4);
        repeat (3) @(negedge clk);
        rst_n = 1;
        gie = 1;
        cyc("R1"); cyc("R1");
        gie = 0;
        // R2: latched while enable clear, offered once set
        hw_req[0] = 1; cyc("R2");
        cyc("R2");
        gie = 1; cyc("R2");
        cyc("R5");
        // R6: acknowledge level 3
        cpu_ack = 1; cyc("R6");
        cyc("R6");
        // R7: level 5 preempts, level 2 does not
        hw_req[1] = 1; cyc("R7");
        cyc("R7");
        cpu_ack = 1; cyc("R6");
        hw_req[2] = 1; cyc("R7");
        cyc("R7");
        // R8: unwind returns
        cpu_reti = 1; cyc("R8");
        cyc("R8");
        cpu_reti = 1; cyc("R8");
        cyc("R8");
        // R3: masked level 7 stays hidden until unmasked
        src_mask[3] = 1; hw_req[3] = 1; cyc("R3");
        cyc("R3");
        src_mask[3] = 0; cyc("R3");
        // R6: request in its own acknowledge cycle stays pending
        cpu_ack = 1; hw_req[3] = 1; cyc("R6");
        cyc("R7");
        cpu_reti = 1; cyc("R8");
        cyc("R6");
        cpu_ack = 1; cyc("R6");
        cpu_reti = 1; cyc("R8");
        // R4: two sources at one level cleared together, level 2 remains
        hw_req[0] = 1; hw_req[4] = 1; cyc("R4");
        cyc("R4");
        cpu_ack = 1; cyc("R6");
        cpu_reti = 1; cyc("R8");
        cyc("R4");
        // R11: raise source 5 at run time
        hw_req[5] = 1; cyc("R11");
        set_prio(5, 6); cyc("R11");
        // R10: acknowledge with irq low
        gie = 0; cpu_ack = 1; cyc("R10");
        gie = 1; cyc("R10");
        // R9: software source
        sw_set = 1; cyc("R9");
        cyc("R9");
        // mixed pseudo-random phase
        lfsr = 16'hACE1;
        for (int i = 0; i < 2000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            hw_req   = (lfsr[5:0] & {lfsr[11:6]}) & 6'h3F;
            sw_set   = lfsr[3] & lfsr[9];
            cpu_ack  = lfsr[1];
            cpu_reti = lfsr[2] & lfsr[7];
            if (lfsr[15:13] == 3'd0) gie = ~gie;
            if (lfsr[12:10] == 3'd5) src_mask = 7'(lfsr[8:2]) & 7'h15;
            if (lfsr[12:10] == 3'd2) set_prio(int'(lfsr[4:2]) % TOT, int'(lfsr[7:5]));
            cyc("R4");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule